// File: doc/BRIEF.md
# Multi-Mode Timer Counter Channel

This block is a single 16-bit down-counting channel for a programmable interval timer. Each pulse on the count-clock enable advances it by one count step, and a gate input qualifies each step. Six behaviours are available: a terminal-count event, a gate-triggered one-shot, a periodic rate generator, a square wave, a strobe triggered by software, and a strobe triggered by the gate. The count can run in plain binary or as four packed decimal digits.

The host bus logic sits outside the block. When software writes a new count, that logic presents the mode, the decimal select and the 16-bit reload value, and pulses the load strobe. A flag reports whether the written value is still waiting to enter the counter. The live count always appears in the same encoding as the reload value: binary, or packed BCD when decimal counting is selected.

Top module: `tmr_channel`

## Requirements
- R1: Synchronous reset gives count 0, out 0 and null_cnt 0. Before the first load, tick has no effect on any output.
- R2: A load cycle stores mode, bcd and reload, and sets null_cnt the next cycle. In the same cycle out becomes 0 for mode 0 and 1 for any other mode code, and count keeps its value. A tick in a load cycle is not counted. Outputs change only on a tick or a load.
- R3: Mode 0 (code 000): the first tick after a load copies reload into count, clears null_cnt and drives out low. Later ticks decrement only while gate is 1. When count reaches 0, out goes high and stays high until the next load.
- R4: Mode 1 (code 001): a sampled gate rising edge loads reload into count and drives out low. After that, each tick decrements regardless of gate. Out goes high when count reaches 0. A new rising edge retriggers.
- R5: Mode 2 (code 010): out is high except for the single tick period that follows a step from 1 to 0. On that step the count reloads instead of showing 0. With gate at 0, counting stops. A gate rising edge reloads the count.
- R6: Mode 3 (code 011): each tick applies two count steps. On each step that reaches 0, the count reloads and out toggles. The gate rules match mode 2. Out starts high after a load.
- R7: Mode 4 (code 100): out stays high. The first tick after a load transfers the count. Later ticks decrement while gate is 1. When count reaches 0, out goes low for exactly one tick period.
- R8: Mode 5 (code 101): a gate rising edge loads the count. When count reaches 0, out goes low for exactly one tick period. Otherwise out stays high.
- R9: Mode codes 110 and 111 behave exactly as codes 010 and 011.
- R10: Decrementing from 0 gives 0xFFFF in binary and 0x9999 in BCD, so a reload of 0 acts as the largest modulus. In binary a step is a decrement by one.
- R11: With bcd = 1, the count is treated as four packed BCD digits, with digit 0 in bits 3:0. A decrement borrows between digits, so 0x0010 steps to 0x0009.
- R12: null_cnt stays 1 until the stored reload is actually copied into the counter. In modes 1 and 5 that happens only on a gate rising edge.
- R13: A gate rising edge counts only when gate is 1 at a tick and was 0 at the previous tick. A gate pulse that falls between two ticks is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-clock enable, one cycle per count period |
| gate | input | 1 | Gate level |
| mode | input | 3 | Operating mode code, stored on load |
| bcd | input | 1 | 1 selects packed decimal counting, stored on load |
| reload | input | 16 | New count value, stored on load |
| load | input | 1 | Strobe: new count and settings written |
| count | output | 16 | Live count, in the reload encoding |
| out | output | 1 | Timer output level |
| null_cnt | output | 1 | 1 while a written count awaits transfer |

## Verification
Each mode runs under three gate patterns. A steady high gate shows the basic period and pulse shapes. A gate that drops for a while separates modes that gate by level from modes that ignore the level. Gate pulses that land on a tick, or fall between ticks, separate edge triggering from level sensing. Reload values of 0, odd and even values, and decimal values that need a borrow across a digit boundary expose the wrap, the uneven square-wave halves and BCD borrow errors. Ticks sometimes come back to back and sometimes with idle cycles between them, which shows whether the state holds between count periods.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int CNT_W   = 16;
    localparam int DIGITS  = CNT_W / 4;
    localparam int SQ_STEPS = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        M_TCINT    = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } mode_e;

    typedef struct packed {
        cnt_t cnt;
        logic out;
        logic nullc;
    } chan_st_t;

    // codes 6 and 7 fold onto 2 and 3
    function automatic mode_e norm_mode(logic [2:0] code);
        if (code[2] && code[1])
            return mode_e'({1'b0, code[1:0]});
        return mode_e'(code);
    endfunction

    // one count step; 0 wraps to the largest value in either encoding
    function automatic cnt_t dec_count(cnt_t c, logic bcd);
        cnt_t r;
        logic borrow;
        if (!bcd)
            return c - cnt_t'(1);
        r = c;
        borrow = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (borrow) begin
                if (r[i*4 +: 4] == 4'd0) begin
                    r[i*4 +: 4] = 4'd9;
                end else begin
                    r[i*4 +: 4] = r[i*4 +: 4] - 4'd1;
                    borrow = 1'b0;
                end
            end
        end
        return r;
    endfunction

    // whether a pending gate edge triggers a reload in this step
    function automatic logic edge_taken(mode_e m, logic nullc, logic edge_in);
        case (m)
            M_ONESHOT, M_HWSTROBE: return edge_in;
            M_RATE, M_SQUARE:      return edge_in & ~nullc;
            default:               return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic gate,
    output logic rise
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst)
            gate_q <= 1'b0;
        else if (tick)
            gate_q <= gate;
    end

    assign rise = gate & ~gate_q;
endmodule

// File: rtl/tmr_step.sv
module tmr_step
    import timer_pkg::*;
(
    input  chan_st_t st_i,
    input  logic     gate_i,
    input  logic     edge_i,
    input  mode_e    mode_i,
    input  logic     bcd_i,
    input  cnt_t     reload_i,
    output chan_st_t st_o
);
    cnt_t nxt;
    logic tc;
    logic take;

    always_comb begin
        nxt  = dec_count(st_i.cnt, bcd_i);
        tc   = (nxt == '0);
        take = edge_taken(mode_i, st_i.nullc, edge_i);
        st_o = st_i;
        case (mode_i)
            M_TCINT: begin
                if (st_i.nullc) begin
                    st_o.cnt = reload_i; st_o.nullc = 1'b0; st_o.out = 1'b0;
                end else if (gate_i) begin
                    st_o.cnt = nxt;
                    if (tc) st_o.out = 1'b1;
                end
            end
            M_ONESHOT: begin
                if (take) begin
                    st_o.cnt = reload_i; st_o.nullc = 1'b0; st_o.out = 1'b0;
                end else if (!st_i.nullc) begin
                    st_o.cnt = nxt;
                    if (tc) st_o.out = 1'b1;
                end
            end
            M_RATE, M_SQUARE: begin
                if (mode_i == M_RATE) st_o.out = 1'b1;
                if (st_i.nullc) begin
                    st_o.cnt = reload_i; st_o.nullc = 1'b0;
                end else if (gate_i) begin
                    if (take) begin
                        st_o.cnt = reload_i;
                    end else if (tc) begin
                        st_o.cnt = reload_i;
                        st_o.out = (mode_i == M_RATE) ? 1'b0 : ~st_i.out;
                    end else begin
                        st_o.cnt = nxt;
                    end
                end
            end
            M_SWSTROBE: begin
                st_o.out = 1'b1;
                if (st_i.nullc) begin
                    st_o.cnt = reload_i; st_o.nullc = 1'b0;
                end else if (gate_i) begin
                    st_o.cnt = nxt;
                    if (tc) st_o.out = 1'b0;
                end
            end
            M_HWSTROBE: begin
                st_o.out = 1'b1;
                if (take) begin
                    st_o.cnt = reload_i; st_o.nullc = 1'b0;
                end else if (!st_i.nullc) begin
                    st_o.cnt = nxt;
                    if (tc) st_o.out = 1'b0;
                end
            end
            default: st_o = st_i;
        endcase
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        gate,
    input  logic [2:0]  mode,
    input  logic        bcd,
    input  logic [15:0] reload,
    input  logic        load,
    output logic [15:0] count,
    output logic        out,
    output logic        null_cnt
);
    chan_st_t st;
    chan_st_t st_next;
    chan_st_t stage [0:SQ_STEPS];
    logic     edge_ch [SQ_STEPS];
    logic     armed;
    logic     bcd_q;
    mode_e    mode_q;
    cnt_t     reload_q;
    logic     rise;

    tmr_gate_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .gate (gate),
        .rise (rise)
    );

    assign stage[0]   = st;
    assign edge_ch[0] = rise;

    for (genvar g = 0; g < SQ_STEPS; g++) begin : g_step
        tmr_step u_step (
            .st_i     (stage[g]),
            .gate_i   (gate),
            .edge_i   (edge_ch[g]),
            .mode_i   (mode_q),
            .bcd_i    (bcd_q),
            .reload_i (reload_q),
            .st_o     (stage[g+1])
        );
        if (g + 1 < SQ_STEPS) begin : g_chain
            assign edge_ch[g+1] = edge_ch[g] & ~edge_taken(mode_q, stage[g].nullc, edge_ch[g]);
        end
    end

    assign st_next = (mode_q == M_SQUARE) ? stage[SQ_STEPS] : stage[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            armed    <= 1'b0;
            mode_q   <= M_TCINT;
            bcd_q    <= 1'b0;
            reload_q <= '0;
        end else if (load) begin
            mode_q   <= norm_mode(mode);
            bcd_q    <= bcd;
            reload_q <= reload;
            armed    <= 1'b1;
            st.nullc <= 1'b1;
            st.out   <= (mode != 3'd0);
        end else if (tick && armed) begin
            st <= st_next;
        end
    end

    assign count    = st.cnt;
    assign out      = st.out;
    assign null_cnt = st.nullc;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        load,
    input logic        gate,
    input logic [2:0]  mode,
    input logic [2:0]  mode_q,
    input logic        bcd_q,
    input logic        armed,
    input logic [15:0] count,
    input logic        out,
    input logic        null_cnt
);
    assert_null_set_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> null_cnt);

    assert_out_init_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (out == ($past(mode) != 3'd0)));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> ($stable(count) && $stable(out) && $stable(null_cnt)));

    assert_tc_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && mode_q == 3'd0 && out && !load) |=> out);

    assert_strobe_width_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && mode_q == 3'd4 && !out && tick && !load) |=> out);

    assert_bin_step_R10: assert property (@(posedge clk) disable iff (rst)
        (armed && tick && !load && mode_q == 3'd4 && !bcd_q && gate && !null_cnt)
        |=> (count == $past(count) - 16'd1));

    assert_wait_trigger_R12: assert property (@(posedge clk) disable iff (rst)
        (armed && mode_q == 3'd1 && null_cnt && !gate && !load) |=> null_cnt);
endmodule

bind tmr_channel tmr_channel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (load),
    .gate     (gate),
    .mode     (mode),
    .mode_q   (mode_q),
    .bcd_q    (bcd_q),
    .armed    (armed),
    .count    (count),
    .out      (out),
    .null_cnt (null_cnt)
);

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        gate = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        bcd = 1'b0;
    logic [15:0] reload = 16'd0;
    logic        load = 1'b0;
    logic [15:0] count;
    logic        out;
    logic        null_cnt;

    int vectors = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R1";

    // reference state
    int m_cnt, m_out, m_null, m_armed, m_mode, m_bcd, m_rel, m_gq;

    always #5 clk = ~clk;

    tmr_channel dut (
        .clk(clk), .rst(rst), .tick(tick), .gate(gate), .mode(mode),
        .bcd(bcd), .reload(reload), .load(load),
        .count(count), .out(out), .null_cnt(null_cnt)
    );

    function automatic int ref_dec(int c, int dec_mode);
        int v;
        if (dec_mode == 0) return (c == 0) ? 65535 : c - 1;
        v = (c & 15) + 10 * ((c >> 4) & 15) + 100 * ((c >> 8) & 15) + 1000 * ((c >> 12) & 15);
        v = (v == 0) ? 9999 : v - 1;
        return (v % 10) | (((v / 10) % 10) << 4) | (((v / 100) % 10) << 8) | (((v / 1000) % 10) << 12);
    endfunction

    task automatic ref_sub(inout bit e);
        int nx;
        bit z;
        nx = ref_dec(m_cnt, m_bcd);
        z = (nx == 0);
        case (m_mode)
            0: if (m_null) begin m_cnt = m_rel; m_null = 0; m_out = 0; end
               else if (gate) begin m_cnt = nx; if (z) m_out = 1; end
            1: if (e) begin m_cnt = m_rel; m_null = 0; m_out = 0; e = 0; end
               else if (!m_null) begin m_cnt = nx; if (z) m_out = 1; end
            2, 3: begin
                if (m_mode == 2) m_out = 1;
                if (m_null) begin m_cnt = m_rel; m_null = 0; end
                else if (gate) begin
                    if (e) begin m_cnt = m_rel; e = 0; end
                    else if (z) begin m_cnt = m_rel; m_out = (m_mode == 2) ? 0 : 1 - m_out; end
                    else m_cnt = nx;
                end
            end
            4: begin
                m_out = 1;
                if (m_null) begin m_cnt = m_rel; m_null = 0; end
                else if (gate) begin m_cnt = nx; if (z) m_out = 0; end
            end
            default: begin
                m_out = 1;
                if (e) begin m_cnt = m_rel; m_null = 0; e = 0; end
                else if (!m_null) begin m_cnt = nx; if (z) m_out = 0; end
            end
        endcase
    endtask

    task automatic ref_edge();
        bit e;
        e = gate && (m_gq == 0);
        if (rst) begin
            m_cnt = 0; m_out = 0; m_null = 0; m_armed = 0; m_mode = 0;
            m_bcd = 0; m_rel = 0; m_gq = 0;
            return;
        end
        if (load) begin
            m_mode = (mode >= 6) ? mode - 4 : mode;
            m_bcd = bcd; m_rel = reload; m_armed = 1; m_null = 1;
            m_out = (mode != 0);
        end else if (tick && m_armed) begin
            for (int k = 0; k < ((m_mode == 3) ? 2 : 1); k++) ref_sub(e);
        end
        if (tick) m_gq = gate;
    endtask

    task automatic cyc(bit tk);
        tick = tk;
        @(posedge clk);
        ref_edge();
        #1;
        vectors++;
        if (count !== m_cnt[15:0] || out !== m_out[0] || null_cnt !== m_null[0]) begin
            errors++;
            $display("FAIL %s: count=%h out=%b null=%b expected count=%h out=%0d null=%0d",
                     cur_req, count, out, null_cnt, m_cnt[15:0], m_out, m_null);
        end
        load = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    task automatic sparse(int n);
        for (int i = 0; i < n; i++) begin cyc(1'b1); cyc(1'b0); end
    endtask

    task automatic prog(int md, bit b, int rv, bit tk);
        mode = md[2:0]; bcd = b; reload = rv[15:0]; load = 1'b1;
        cyc(tk);
    endtask

    initial begin
        cur_req = "R1";
        cyc(1'b0); cyc(1'b1); cyc(1'b0);
        rst = 1'b0;
        gate = 1'b1;
        run(3);                                   // R1: not armed yet
        cur_req = "R2";
        prog(0, 0, 5, 1'b1);                      // R2: tick in load cycle ignored
        cyc(1'b0); cyc(1'b0);
        cur_req = "R3";
        run(3); gate = 1'b0; run(3); gate = 1'b1; sparse(6); run(3);
        cur_req = "R4";
        gate = 1'b0; prog(1, 0, 3, 1'b0);
        cur_req = "R12";
        run(3);
        cur_req = "R4";
        gate = 1'b1; run(2); gate = 1'b0; run(1); gate = 1'b1; run(6);
        cur_req = "R5";
        prog(2, 0, 4, 1'b0); run(10); gate = 1'b0; run(2); gate = 1'b1; run(6);
        cur_req = "R6";
        prog(3, 0, 6, 1'b0); run(12);
        prog(3, 0, 5, 1'b0); run(12); gate = 1'b0; run(2); gate = 1'b1; run(5);
        gate = 1'b0; run(1); prog(3, 0, 7, 1'b0); gate = 1'b1; run(8);
        cur_req = "R7";
        prog(4, 0, 3, 1'b0); run(8); gate = 1'b0; run(2); gate = 1'b1; sparse(5);
        cur_req = "R8";
        gate = 1'b0; prog(5, 0, 2, 1'b0); run(2); gate = 1'b1; run(4);
        gate = 1'b0; run(1); gate = 1'b1; run(5);
        cur_req = "R9";
        prog(6, 0, 3, 1'b0); run(8);
        prog(7, 0, 4, 1'b0); run(10);
        cur_req = "R10";
        prog(0, 0, 0, 1'b0); run(4);
        prog(4, 1, 0, 1'b0); run(3);
        cur_req = "R11";
        prog(2, 1, 16'h0012, 1'b0); run(20);
        prog(3, 1, 16'h0100, 1'b0); run(6);
        cur_req = "R13";
        gate = 1'b0; prog(5, 0, 3, 1'b0); run(1);
        gate = 1'b1; cyc(1'b0); cyc(1'b0); gate = 1'b0; cyc(1'b0);
        run(3);                                   // pulse missed: still waiting
        gate = 1'b1; cyc(1'b0); cyc(1'b0); run(6);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule